// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves translation-buffer misses in hardware. When the translation buffer cannot map a virtual page, it hands the virtual page number to the walker. The walker computes where that page's entry sits in the current process's table, which lives in physical memory. It reads the entry over a request/acknowledge memory port whose latency varies. It then decodes the entry's valid bit, access-rights field and physical frame number.

A resident page (valid bit set) produces a one-cycle refill pulse carrying the frame number and the access rights, which the translation buffer installs. A non-resident page (valid bit clear) means the frame field points to backing storage instead of a frame, so the walker raises a one-cycle fault pulse carrying the virtual page number. No refill is produced in that case.

The table base is held in a register inside the walker. Software loads it on a context switch. A load that arrives in the middle of a walk is parked and applied once the walker is idle again, so a walk never sees its base change under it.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_req`, `refill_valid` and `fault_valid` are all low.
- R2: The read address presented on `mem_addr` while `mem_req` is high equals the table base plus four times the virtual page number being walked, wrapping at `PA_W` bits.
- R3: Each walk issues exactly one read. `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_ack` is high, and it is low in the following cycle.
- R4: If bit 31 of the returned entry is 1, then in the second cycle after the acknowledge cycle `refill_valid` is high for exactly one cycle. During that cycle `refill_vpn` is the walked page number, `refill_ppn` is entry bits 19..0, and `refill_rights` is entry bits 30..29 (0 none, 1 read-only, 2 read/write, 3 execute).
- R5: If bit 31 of the returned entry is 0, then in the second cycle after the acknowledge cycle `fault_valid` is high for exactly one cycle with `fault_vpn` equal to the walked page number, and `refill_valid` stays low.
- R6: `busy` rises in the cycle after a miss is accepted, stays high through the refill or fault cycle, and is low in the cycle after it.
- R7: A miss request presented while `busy` is high is dropped. It causes no further read, no further refill or fault, and does not change the page number of the current walk.
- R8: A base write made while the walker is idle is used by the next walk, including a walk whose miss arrives in the same cycle as the write.
- R9: A base write made during a walk does not affect that walk's address. It is applied when the walk ends, and of several such writes the last one wins.
- R10: Entry bits 28..20 are reserved and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation-buffer miss request |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| busy | output | 1 | Walk in progress |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_data | input | PA_W | New table base (physical address) |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | PA_W | Physical address of the entry being read |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 32 | Returned table entry |
| refill_valid | output | 1 | One-cycle refill pulse |
| refill_vpn | output | VPN_W | Page number being refilled |
| refill_ppn | output | 20 | Physical frame number of the refill |
| refill_rights | output | 2 | Access rights of the refill |
| fault_valid | output | 1 | One-cycle page fault pulse |
| fault_vpn | output | VPN_W | Page number that faulted |

## Verification
Every cycle, the bound checker confirms the reset state and the memory handshake. It checks that a pending request holds its address until acknowledged and drops right after. It also checks that refill and fault pulses last one cycle and never overlap, that `busy` follows miss acceptance, and that entry addresses are word aligned. The bench scenarios are needed for the checks that depend on data:
- the exact address computed from the base and page number, and the decoded frame and rights compared against the entry the memory returned;
- parked base writes taking effect only for the following walk, with the last one winning;
- misses raised during a walk being dropped without a second read.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int PTE_W         = 32;
    localparam int PTE_PRESENT_B = 31;
    localparam int PTE_PERM_LSB  = 29;
    localparam int PTE_PERM_W    = 2;
    localparam int PTE_FRAME_W   = 20;
    localparam int PTE_BYTES_LOG = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_CHECK  = 3'd3,
        ST_REFILL = 3'd4,
        ST_FAULT  = 3'd5
    } walk_state_e;

    typedef enum logic [PTE_PERM_W-1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_EXEC = 2'd3
    } perm_e;

    typedef struct packed {
        logic                   present;
        perm_e                  perm;
        logic [PTE_FRAME_W-1:0] frame;
    } pte_fields_t;

    // Pull the meaningful fields out of a raw entry; reserved bits are dropped.
    function automatic pte_fields_t pte_unpack(input logic [PTE_W-1:0] raw);
        pte_fields_t f;
        f.present = raw[PTE_PRESENT_B];
        f.perm    = perm_e'(raw[PTE_PERM_LSB +: PTE_PERM_W]);
        f.frame   = raw[PTE_FRAME_W-1:0];
        return f;
    endfunction

    function automatic logic is_terminal(input walk_state_e s);
        return (s == ST_REFILL) || (s == ST_FAULT);
    endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
    import pt_walk_pkg::*;
#(
    parameter int              PA_W       = 32,
    parameter logic [PA_W-1:0] BASE_RESET = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            idle,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    output logic [PA_W-1:0] base_o
);

    logic [PA_W-1:0] base_q;
    logic [PA_W-1:0] park_q;
    logic            park_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= BASE_RESET;
            park_q     <= '0;
            park_vld_q <= 1'b0;
        end else if (idle) begin
            // A fresh write in an idle cycle supersedes anything parked.
            if (wr_en) begin
                base_q <= wr_data;
            end else if (park_vld_q) begin
                base_q <= park_q;
            end
            park_vld_q <= 1'b0;
        end else if (wr_en) begin
            park_q     <= wr_data;
            park_vld_q <= 1'b1;
        end
    end

    assign base_o = base_q;

endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        miss_valid,
    input  logic        mem_ack,
    input  logic        entry_present,
    output walk_state_e state_o,
    output logic        accept_o,
    output logic        capture_o
);

    walk_state_e st_q;
    walk_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (miss_valid) st_d = ST_ISSUE;
            ST_ISSUE:  st_d = ST_WAIT;
            ST_WAIT:   if (mem_ack) st_d = ST_CHECK;
            ST_CHECK:  st_d = entry_present ? ST_REFILL : ST_FAULT;
            ST_REFILL: st_d = ST_IDLE;
            ST_FAULT:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign state_o   = st_q;
    assign accept_o  = (st_q == ST_IDLE) && miss_valid;
    assign capture_o = (st_q == ST_WAIT) && mem_ack;

endmodule

// File: rtl/ptw_pte_latch.sv
module ptw_pte_latch
    import pt_walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [PTE_W-1:0] raw,
    output pte_fields_t      fields_o
);

    pte_fields_t fields_q;
    logic        rsvd_unused;

    assign rsvd_unused = ^raw[PTE_PERM_LSB-1:PTE_FRAME_W];

    always_ff @(posedge clk) begin
        if (rst)          fields_q <= '0;
        else if (capture) fields_q <= pte_unpack(raw);
    end

    assign fields_o = fields_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int              VPN_W      = 20,
    parameter int              PA_W       = 32,
    parameter logic [PA_W-1:0] BASE_RESET = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   miss_valid,
    input  logic [VPN_W-1:0]       miss_vpn,
    output logic                   busy,
    input  logic                   base_wr_en,
    input  logic [PA_W-1:0]        base_wr_data,
    output logic                   mem_req,
    output logic [PA_W-1:0]        mem_addr,
    input  logic                   mem_ack,
    input  logic [PTE_W-1:0]       mem_rdata,
    output logic                   refill_valid,
    output logic [VPN_W-1:0]       refill_vpn,
    output logic [PTE_FRAME_W-1:0] refill_ppn,
    output logic [PTE_PERM_W-1:0]  refill_rights,
    output logic                   fault_valid,
    output logic [VPN_W-1:0]       fault_vpn
);

    localparam int OFS_W = VPN_W + PTE_BYTES_LOG;

    walk_state_e     st;
    logic            accept;
    logic            capture;
    logic [PA_W-1:0] base;
    logic [VPN_W-1:0] vpn_q;
    logic [PA_W-1:0] addr_q;
    pte_fields_t     pte;
    logic [OFS_W-1:0] ofs;

    ptw_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .miss_valid    (miss_valid),
        .mem_ack       (mem_ack),
        .entry_present (pte.present),
        .state_o       (st),
        .accept_o      (accept),
        .capture_o     (capture)
    );

    ptw_base_reg #(.PA_W(PA_W), .BASE_RESET(BASE_RESET)) u_base (
        .clk     (clk),
        .rst     (rst),
        .idle    (st == ST_IDLE),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base_o  (base)
    );

    ptw_pte_latch u_pte (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .raw      (mem_rdata),
        .fields_o (pte)
    );

    assign ofs = {vpn_q, {PTE_BYTES_LOG{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q  <= '0;
            addr_q <= '0;
        end else begin
            if (accept) vpn_q <= miss_vpn;
            if (st == ST_ISSUE) addr_q <= base + PA_W'(ofs);
        end
    end

    assign busy          = (st != ST_IDLE);
    assign mem_req       = (st == ST_WAIT);
    assign mem_addr      = addr_q;
    assign refill_valid  = (st == ST_REFILL);
    assign refill_vpn    = vpn_q;
    assign refill_ppn    = pte.frame;
    assign refill_rights = pte.perm;
    assign fault_valid   = is_terminal(st) && (st == ST_FAULT);
    assign fault_vpn     = vpn_q;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int VPN_W = 20,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            miss_valid,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_ack,
    input logic [PA_W-1:0] mem_addr,
    input logic            refill_valid,
    input logic            fault_valid
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !mem_req && !refill_valid && !fault_valid));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req);

    // R4
    refill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        refill_valid |=> (!refill_valid && !busy));

    // R5
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> (!fault_valid && !busy));

    // R5
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(refill_valid && fault_valid));

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !busy) |=> busy);

    // R6
    end_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (refill_valid || fault_valid) |-> busy);

endmodule

bind pt_walker ptw_checker #(.VPN_W(VPN_W), .PA_W(PA_W)) u_ptw_checker (
    .clk          (clk),
    .rst          (rst),
    .miss_valid   (miss_valid),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .refill_valid (refill_valid),
    .fault_valid  (fault_valid)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

    localparam int VPN_W = 20;
    localparam int PA_W  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             miss_valid = 1'b0;
    logic [VPN_W-1:0] miss_vpn = '0;
    logic             busy;
    logic             base_wr_en = 1'b0;
    logic [PA_W-1:0]  base_wr_data = '0;
    logic             mem_req;
    logic [PA_W-1:0]  mem_addr;
    logic             mem_ack = 1'b0;
    logic [31:0]      mem_rdata = '0;
    logic             refill_valid;
    logic [VPN_W-1:0] refill_vpn;
    logic [19:0]      refill_ppn;
    logic [1:0]       refill_rights;
    logic             fault_valid;
    logic [VPN_W-1:0] fault_vpn;

    pt_walker #(.VPN_W(VPN_W), .PA_W(PA_W)) u_pt_walker (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .busy(busy), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .refill_valid(refill_valid),
        .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .refill_rights(refill_rights), .fault_valid(fault_valid),
        .fault_vpn(fault_vpn)
    );

    int total = 0;
    int bad = 0;
    int reads = 0;
    int lat = 0;
    bit force_en = 1'b0;
    logic [31:0] force_word = '0;
    logic [PA_W-1:0] last_addr = '0;
    logic [PA_W-1:0] base_m = '0;

    function automatic logic [31:0] table_word(input logic [PA_W-1:0] a);
        return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]};
    endfunction

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] b,
                                                   input logic [VPN_W-1:0] v);
        return b + PA_W'({v, 2'b00});
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Memory model: answers each request after lat extra cycles.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                reads++;
                last_addr = mem_addr;
                repeat (lat) @(negedge clk);
                mem_rdata = force_en ? force_word : table_word(mem_addr);
                mem_ack = 1'b1;
            end
        end
    end

    // base_mode: 0 none, 1 one write mid-walk, 2 two writes mid-walk (last wins)
    task automatic walk(input logic [VPN_W-1:0] vpn, input bit intrude,
                        input int base_mode, input logic [PA_W-1:0] new_base);
        int r0;
        int n;
        logic [31:0] w;
        logic [PA_W-1:0] exp_addr;
        r0 = reads;
        exp_addr = entry_addr(base_m, vpn);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_vpn = vpn;
        @(negedge clk);
        miss_valid = 1'b0;
        chk("R6 busy after accept", busy, 1);
        if (intrude) begin
            miss_valid = 1'b1;
            miss_vpn = ~vpn;
        end
        if (base_mode != 0) begin
            base_wr_en = 1'b1;
            base_wr_data = (base_mode == 2) ? (new_base ^ 32'h00FF_F000) : new_base;
        end
        n = 0;
        while (!(refill_valid || fault_valid) && n < 200) begin
            @(negedge clk);
            if (n == 0 && base_mode == 2) base_wr_data = new_base;
            else base_wr_en = 1'b0;
            if (n > 2) miss_valid = 1'b0;
            n++;
        end
        miss_valid = 1'b0;
        base_wr_en = 1'b0;
        chk("R6 walk ends", (n < 200), 1);
        w = force_en ? force_word : table_word(exp_addr);
        chk("R2 entry address", last_addr, exp_addr);
        chk("R3 one read per walk (R7)", reads, r0 + 1);
        if (w[31]) begin
            chk("R4 refill_valid", refill_valid, 1);
            chk("R5 no fault on present", fault_valid, 0);
            chk("R4 refill_vpn (R7)", refill_vpn, vpn);
            chk("R4 refill_ppn", refill_ppn, w[19:0]);
            chk("R4 refill_rights", refill_rights, w[30:29]);
        end else begin
            chk("R5 fault_valid", fault_valid, 1);
            chk("R5 no refill on fault", refill_valid, 0);
            chk("R5 fault_vpn (R7)", fault_vpn, vpn);
        end
        @(negedge clk);
        chk("R6 busy low after end", busy, 0);
        chk("R4 pulse one cycle", refill_valid | fault_valid, 0);
        if (base_mode != 0) base_m = new_base;
        if (intrude) begin
            repeat (4) @(negedge clk);
            chk("R7 no walk from dropped miss", busy, 0);
            chk("R7 no extra read", reads, r0 + 1);
        end
    endtask

    task automatic write_base_idle(input logic [PA_W-1:0] b);
        @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
        base_m = b;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 mem_req in reset", mem_req, 0);
        chk("R1 outputs in reset", {refill_valid, fault_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 quiet after reset", {busy, mem_req, refill_valid, fault_valid}, 0);

        // R8: idle base write then walk
        write_base_idle(32'h0040_0000);
        lat = 0;
        walk(20'h00003, 1'b0, 0, '0);

        // R8: write and miss in the same idle cycle
        @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = 32'h0080_0000;
        base_m = 32'h0080_0000;
        walk(20'h00010, 1'b0, 0, '0);

        // R4 / R10: directed entries, reserved bits toggled
        force_en = 1'b1;
        force_word = {1'b1, 2'd2, 9'h1FF, 20'hABCDE};
        walk(20'h00011, 1'b0, 0, '0);
        force_word = {1'b1, 2'd2, 9'h000, 20'hABCDE};
        walk(20'h00011, 1'b0, 0, '0);
        force_word = {1'b1, 2'd3, 9'h0A5, 20'h00001};
        walk(20'hFFFFF, 1'b0, 0, '0);
        force_word = {1'b1, 2'd0, 9'h000, 20'hFFFFF};
        walk(20'h00000, 1'b0, 0, '0);
        // R5: not resident, frame field nonzero
        force_word = {1'b0, 2'd1, 9'h1FF, 20'h12345};
        lat = 5;
        walk(20'h00777, 1'b0, 0, '0);
        force_en = 1'b0;

        // R7: miss during walk dropped
        lat = 4;
        walk(20'h00123, 1'b1, 0, '0);

        // R9: mid-walk base write held; then two writes, last wins
        lat = 6;
        walk(20'h00200, 1'b0, 1, 32'h0100_0000);
        walk(20'h00201, 1'b0, 2, 32'h0200_0000);
        walk(20'h00202, 1'b0, 0, '0);

        // Random walks
        for (int i = 0; i < 60; i++) begin
            logic [VPN_W-1:0] v;
            int mode;
            v = VPN_W'($urandom);
            lat = int'($urandom % 7);
            mode = ($urandom % 5 == 0) ? 1 : 0;
            if ($urandom % 6 == 0)
                write_base_idle({$urandom} & 32'hFFFF_F000);
            walk(v, ($urandom % 4 == 0), mode, {$urandom} & 32'hFFFF_F000);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule